// File: doc/BRIEF.md
# Processor Bus Machine-Cycle Sequencer

This block times one external bus transaction of an 8-bit processor with a 16-bit address bus. The block runs on a clock at twice the bus clock rate, so each rising edge of `clk` is one half-step of a bus clock. A request names a cycle kind, an address and write data. The sequencer then steps through a fixed start phase, an optional run of forced extra clocks, the wait sample point, an optional forced extra clock after the sample, and a fixed end phase. It raises the matching strobe, holds the address, drives write data when it is needed, and captures read data on the final half-step.

The wait input is sampled only at the sample point. Each sample that finds it high inserts one whole bus clock and samples it again. Two four-clock read kinds have the same length but place their forced clock on opposite sides of the wait sample. One puts it before, for reads whose address is computed first. The other puts it after, for reads that are followed by internal work such as the read half of a read-modify-write. A request is accepted only while the block is idle. The `done` pulse ends each cycle.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held, and straight after it, `busy`, `done`, `dataOe` and all four strobes are 0 and `rdData` is 0.
- R2: `reqKind` encodes 0 = read 3 clk, 1 = read 4 clk with extra clock before the wait sample, 2 = read 4 clk with extra clock after the sample, 3 = read 5 clk, 4 = write 3 clk, 5 = write 5 clk, 6 = I/O input, 7 = I/O output. With wait low, `done` is seen in the half-step that follows K edges after the accepting edge, where K is 6, 8, 8, 10, 6, 10, 8 and 8 for kinds 0 through 7.
- R3: The wait input is sampled on the edge 3 + 2·P half-steps after acceptance, where P is the number of forced clocks before the sample (1 for kinds 1, 6 and 7, 2 for kinds 3 and 5, otherwise 0). Each sample that finds it high adds 2 half-steps and samples again 2 half-steps later.
- R4: Kind 1 samples wait at half-step 5 and kind 2 samples at half-step 3. Both are 8 half-steps long with wait low.
- R5: At most one strobe is active at a time. `memRd` is used for kinds 0–3, `memWr` for kinds 4–5, `ioRd` for kind 6 and `ioWr` for kind 7. The strobe is low in the first and last half-steps and high in the half-steps between them.
- R6: While busy, `addrOut` carries the accepted address. `dataOe` is high exactly for kinds 4, 5 and 7.
- R7: For kinds 0–3 and 6, `rdData` takes the value of `dataIn` at the final edge of the cycle. For the other kinds, `rdData` keeps its value.
- R8: `done` is high for exactly one half-step, and `busy` is low in that half-step.
- R9: A request raised while busy is ignored. It changes neither the address, the kind nor the length of the running cycle, and it does not start a cycle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-step clock (twice the bus clock rate) |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request pulse, taken only when idle |
| reqKind | input | 3 | Cycle kind (encoding in R2) |
| reqAddr | input | 16 | Cycle address |
| reqData | input | 8 | Write data for write and output cycles |
| waitReq | input | 1 | Active-high wait request |
| dataIn | input | 8 | Bus data sampled at the end of read and input cycles |
| addrOut | output | 16 | Bus address |
| dataOut | output | 8 | Bus write data |
| dataOe | output | 1 | Write data drive enable |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| ioRd | output | 1 | I/O input strobe |
| ioWr | output | 1 | I/O output strobe |
| rdData | output | 8 | Captured read data |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-half-step end-of-cycle pulse |

## Verification
Every result is timed from the edge that accepts the request. The strobes become valid in the second half-step and fall in half-step K. `done` and `rdData` become visible after edge K, and the wait input matters only at edge 3 + 2·P and every 2 half-steps after that while it stays high. The bench counts rising edges from acceptance and samples outputs on the following falling edge. It lowers the wait input on the falling edge after the last sample edge it intends to stretch. A sequencer that puts the sample point elsewhere therefore produces a different length. Each kind is run with zero, one and two wait samples.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  typedef enum logic [2:0] {
    KIND_RD3       = 3'd0,
    KIND_RD4_EARLY = 3'd1,
    KIND_RD4_LATE  = 3'd2,
    KIND_RD5       = 3'd3,
    KIND_WR3       = 3'd4,
    KIND_WR5       = 3'd5,
    KIND_IN        = 3'd6,
    KIND_OUT       = 3'd7
  } cycleKind_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_PRE, PH_WAIT, PH_POST, PH_END
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic capture;
  } dpCtl_t;

  // forced bus clocks placed ahead of the wait sample
  function automatic int preClks(cycleKind_t k);
    case (k)
      KIND_RD4_EARLY, KIND_IN, KIND_OUT: return 1;
      KIND_RD5, KIND_WR5:                return 2;
      default:                           return 0;
    endcase
  endfunction

  // forced bus clocks placed after the wait sample
  function automatic int postClks(cycleKind_t k);
    return (k == KIND_RD4_LATE) ? 1 : 0;
  endfunction

  function automatic logic capturesData(cycleKind_t k);
    return (k == KIND_RD3) || (k == KIND_RD4_EARLY) || (k == KIND_RD4_LATE) ||
           (k == KIND_RD5) || (k == KIND_IN);
  endfunction

  function automatic logic drivesData(cycleKind_t k);
    return (k == KIND_WR3) || (k == KIND_WR5) || (k == KIND_OUT);
  endfunction

  function automatic logic isIo(cycleKind_t k);
    return (k == KIND_IN) || (k == KIND_OUT);
  endfunction

endpackage

// File: rtl/busseq_ctrl.sv
module busseq_ctrl
  import busseq_pkg::*;
#(
  parameter int START_HALVES   = 3,
  parameter int END_HALVES     = 3,
  parameter int HALVES_PER_CLK = 2,
  parameter int MAX_FORCED     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  input  logic       waitReq,
  output dpCtl_t     ctl,
  output logic       memRd,
  output logic       memWr,
  output logic       ioRd,
  output logic       ioWr,
  output logic       dataOe,
  output logic       busy,
  output logic       done
);

  localparam int FORCED_MAX = MAX_FORCED * HALVES_PER_CLK;
  localparam int MAX_LOAD_A = (START_HALVES > END_HALVES) ? START_HALVES : END_HALVES;
  localparam int MAX_LOAD   = (MAX_LOAD_A > FORCED_MAX) ? MAX_LOAD_A : FORCED_MAX;
  localparam int CNT_W      = $clog2(MAX_LOAD + 1);
  localparam logic [CNT_W-1:0] START_LOAD = CNT_W'(START_HALVES - 1);
  localparam logic [CNT_W-1:0] END_LOAD   = CNT_W'(END_HALVES - 1);
  localparam logic [CNT_W-1:0] WAIT_LOAD  = CNT_W'(HALVES_PER_CLK - 1);

  phase_t           phase, phaseD;
  logic [CNT_W-1:0] cnt, cntD;
  cycleKind_t       kindQ;
  logic             doneQ;
  logic             lastHalf;
  logic             hasPre, hasPost;
  logic [CNT_W-1:0] preLoad, postLoad;
  phase_t           samplePhase;
  logic [CNT_W-1:0] sampleCnt;
  logic             strobeOn;

  assign lastHalf = (cnt == '0);
  assign hasPre   = (preClks(kindQ) != 0);
  assign hasPost  = (postClks(kindQ) != 0);
  assign preLoad  = CNT_W'(preClks(kindQ) * HALVES_PER_CLK - 1);
  assign postLoad = CNT_W'(postClks(kindQ) * HALVES_PER_CLK - 1);

  // outcome of the wait sample point
  always_comb begin
    if (waitReq) begin
      samplePhase = PH_WAIT;
      sampleCnt   = WAIT_LOAD;
    end else if (hasPost) begin
      samplePhase = PH_POST;
      sampleCnt   = postLoad;
    end else begin
      samplePhase = PH_END;
      sampleCnt   = END_LOAD;
    end
  end

  always_comb begin
    phaseD      = phase;
    cntD        = lastHalf ? '0 : cnt - 1'b1;
    ctl.load    = 1'b0;
    ctl.capture = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          phaseD   = PH_START;
          cntD     = START_LOAD;
          ctl.load = 1'b1;
        end
      end
      PH_START: begin
        if (lastHalf) begin
          if (hasPre) begin
            phaseD = PH_PRE;
            cntD   = preLoad;
          end else begin
            phaseD = samplePhase;
            cntD   = sampleCnt;
          end
        end
      end
      PH_PRE, PH_WAIT: begin
        if (lastHalf) begin
          phaseD = samplePhase;
          cntD   = sampleCnt;
        end
      end
      PH_POST: begin
        if (lastHalf) begin
          phaseD = PH_END;
          cntD   = END_LOAD;
        end
      end
      PH_END: begin
        if (lastHalf) begin
          phaseD      = PH_IDLE;
          ctl.capture = capturesData(kindQ);
        end
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      kindQ <= KIND_RD3;
      doneQ <= 1'b0;
    end else begin
      phase <= phaseD;
      cnt   <= cntD;
      doneQ <= (phase == PH_END) && lastHalf;
      if (ctl.load) kindQ <= cycleKind_t'(reqKind);
    end
  end

  assign busy     = (phase != PH_IDLE);
  assign done     = doneQ;
  assign strobeOn = busy && !((phase == PH_START) && (cnt == START_LOAD))
                         && !((phase == PH_END) && lastHalf);
  assign memRd    = strobeOn && !isIo(kindQ) && !drivesData(kindQ);
  assign memWr    = strobeOn && !isIo(kindQ) && drivesData(kindQ);
  assign ioRd     = strobeOn && (kindQ == KIND_IN);
  assign ioWr     = strobeOn && (kindQ == KIND_OUT);
  assign dataOe   = busy && drivesData(kindQ);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRd, memWr, ioRd, ioWr}));
  // R5
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr || ioRd || ioWr) |-> busy);
  // R9
  kind_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || $stable(kindQ)));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/busseq_dp.sv
module busseq_dp
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdQ    <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqData;
      end
      if (ctl.capture) rdQ <= dataIn;
    end
  end

  assign addrOut = addrQ;
  assign dataOut = wdataQ;
  assign rdData  = rdQ;

  // R9
  accept_vs_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.load && ctl.capture));

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import busseq_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 8,
  parameter int START_HALVES   = 3,
  parameter int END_HALVES     = 3,
  parameter int HALVES_PER_CLK = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              waitReq,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              memRd,
  output logic              memWr,
  output logic              ioRd,
  output logic              ioWr,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done
);

  dpCtl_t ctl;

  busseq_ctrl #(
    .START_HALVES  (START_HALVES),
    .END_HALVES    (END_HALVES),
    .HALVES_PER_CLK(HALVES_PER_CLK),
    .MAX_FORCED    (2)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqKind (reqKind),
    .waitReq (waitReq),
    .ctl     (ctl),
    .memRd   (memRd),
    .memWr   (memWr),
    .ioRd    (ioRd),
    .ioWr    (ioWr),
    .dataOe  (dataOe),
    .busy    (busy),
    .done    (done)
  );

  busseq_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .reqAddr(reqAddr),
    .reqData(reqData),
    .dataIn (dataIn),
    .addrOut(addrOut),
    .dataOut(dataOut),
    .rdData (rdData)
  );

endmodule

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [2:0]  reqKind;
  logic [15:0] reqAddr;
  logic [7:0]  reqData;
  logic        waitReq;
  logic [7:0]  dataIn;
  logic [15:0] addrOut;
  logic [7:0]  dataOut;
  logic        dataOe, memRd, memWr, ioRd, ioWr, busy, done;
  logic [7:0]  rdData;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqData(reqData), .waitReq(waitReq), .dataIn(dataIn),
    .addrOut(addrOut), .dataOut(dataOut), .dataOe(dataOe), .memRd(memRd),
    .memWr(memWr), .ioRd(ioRd), .ioWr(ioWr), .rdData(rdData), .busy(busy),
    .done(done)
  );

  // {kind, forced clocks before sample, wait samples, expected half-steps}
  localparam int VEC [0:23][0:3] = '{
    '{0,0,0,6}, '{1,1,0,8}, '{2,0,0,8}, '{3,2,0,10},
    '{4,0,0,6}, '{5,2,0,10}, '{6,1,0,8}, '{7,1,0,8},
    '{0,0,1,8}, '{1,1,1,10}, '{2,0,1,10}, '{3,2,1,12},
    '{4,0,1,8}, '{5,2,1,12}, '{6,1,1,10}, '{7,1,1,10},
    '{0,0,2,10}, '{1,1,2,12}, '{2,0,2,12}, '{3,2,2,14},
    '{4,0,2,10}, '{5,2,2,14}, '{6,1,2,12}, '{7,1,2,12}
  };

  task automatic chkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int strobeFor(input int kind);
    if (kind <= 3) return 4'b1000;
    if (kind <= 5) return 4'b0100;
    if (kind == 6) return 4'b0010;
    return 4'b0001;
  endfunction

  function automatic int strobesNow();
    return int'({memRd, memWr, ioRd, ioWr});
  endfunction

  task automatic runCycle(input int kind, input int pre, input int waits,
                          input int expLen, input logic [15:0] addr,
                          input logic [7:0] wdata, input logic [7:0] rpat);
    int n;
    logic [7:0] prevRd;
    string lenTag;
    lenTag = (waits == 0) ? "R2" : ((kind == 1 || kind == 2) ? "R4" : "R3");
    @(negedge clk);
    prevRd   = rdData;
    reqValid = 1'b1;
    reqKind  = 3'(kind);
    reqAddr  = addr;
    reqData  = wdata;
    dataIn   = rpat;
    waitReq  = (waits > 0);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chkEq("R5 first half strobe", strobesNow(), 0);
    n = 0;
    while (!done && n < 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (waits > 0 && n == 3 + 2 * pre + 2 * (waits - 1)) waitReq = 1'b0;
      if (n == 1) begin
        chkEq("R5 strobe kind", strobesNow(), strobeFor(kind));
        chkEq("R6 address", int'(addrOut), int'(addr));
        chkEq("R6 dataOe", int'(dataOe), (kind == 4 || kind == 5 || kind == 7) ? 1 : 0);
        if (kind == 4 || kind == 5 || kind == 7)
          chkEq("R6 write data", int'(dataOut), int'(wdata));
      end
      if (!done && n == expLen - 1) chkEq("R5 last half strobe", strobesNow(), 0);
    end
    waitReq = 1'b0;
    chkEq(lenTag, n, expLen);
    chkEq("R8 busy at done", int'(busy), 0);
    chkEq("R7 read data", int'(rdData),
          (kind <= 3 || kind == 6) ? int'(rpat) : int'(prevRd));
    @(negedge clk);
    chkEq("R8 done width", int'(done), 0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rstN = 1'b0; reqValid = 1'b0; reqKind = '0; reqAddr = '0; reqData = '0;
    waitReq = 1'b0; dataIn = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chkEq("R1 busy", int'(busy), 0);
    chkEq("R1 strobes", strobesNow(), 0);
    chkEq("R1 done", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1 rdData", int'(rdData), 0);
    chkEq("R1 dataOe", int'(dataOe), 0);

    for (int i = 0; i < 24; i++)
      runCycle(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3],
               16'h1000 + 16'(i * 257), 8'(8'h40 + i), 8'(8'hA5 ^ (i * 7)));

    // read-modify-write pair on one address
    runCycle(2, 0, 0, 8, 16'hBEEF, 8'h00, 8'h3C);
    runCycle(4, 0, 0, 6, 16'hBEEF, 8'h3D, 8'h00);

    // R9: request while busy is ignored
    @(negedge clk);
    reqValid = 1'b1; reqKind = 3'd0; reqAddr = 16'h2222; waitReq = 1'b0;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqKind = 3'd5; reqAddr = 16'h7777;
    @(negedge clk);
    reqValid = 1'b0;
    chkEq("R9 address kept", int'(addrOut), 16'h2222);
    chkEq("R9 strobe kept", strobesNow(), 4'b1000);
    n = 2;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chkEq("R9 length kept", n, 6);
    @(negedge clk);
    chkEq("R9 no late start", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule